// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a small number of pages. Each slot has its own tag comparator, so a lookup checks every slot in the same cycle, and any page can sit in any slot. Each slot stores a valid flag, a referenced flag, a modified flag, read, write and execute permissions, and a 20-bit frame number. A lookup that finds no valid slot raises a miss trap. Software then walks its own page tables, writes the translation through the fill port and retries the access.

Lookups enter on a valid/ready request channel. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold the request steady while `req_ready` is low. `req_ready` drops only in a cycle where a fill is presented, because a fill takes precedence over a lookup. The response is a single-cycle pulse on `rsp_valid` and cannot be back-pressured. Fill and invalidate commands are plain control pins and act on the edge where they are sampled high. A context switch clears the whole buffer. A single-page invalidate removes one stale mapping.

Top module: `xlat_buf`

## Requirements
- R1: Any page can be held in any slot. With all ENTRIES slots filled with distinct pages, a lookup of each page hits and returns the frame number that was filled for it.
- R2: A slot whose valid flag is clear never hits. Right after reset, every lookup misses.
- R3: A lookup whose page matches no valid slot produces a response with `rsp_miss`=1, `rsp_hit`=0, `rsp_fault`=0 and `rsp_pfn`=0. Every response has exactly one of hit, miss and fault set.
- R4: When `inv_all` is high on an edge, every slot becomes invalid. A fill presented on the same edge is still written and stays valid.
- R5: When `inv_one` is high on an edge, only the slot that matches `inv_vpn` becomes invalid. If no slot matches, nothing changes.
- R6: Access type codes are 0 read, 1 write, 2 execute. A permitted access that matches a slot returns `rsp_hit`=1 with the slot's frame number, and sets the slot's referenced flag. Only a write also sets its modified flag. `rsp_ref` and `rsp_mod` report the slot's flags after this update.
- R7: Permission bits are bit 0 read, bit 1 write, bit 2 execute. An access that matches a slot whose permission bit for that access type is clear returns `rsp_fault`=1, `rsp_hit`=0 and `rsp_pfn`=0, and leaves both flags unchanged. Access code 3 faults on any matching slot.
- R8: A fill picks its slot in this order: the slot already holding that page, else the lowest-numbered invalid slot, else a pseudo-random slot from a free-running LFSR. Exactly one slot is rewritten, and no page is ever held twice.
- R9: A response appears exactly one cycle after the request is accepted. `req_ready` is low in any cycle where `fill_valid` is high, and is high otherwise (including right after reset).
- R10: A fill loads the given frame number and permissions and clears the slot's referenced and modified flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vpn | input | VPN_W | Virtual page to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_hit | output | 1 | Permitted translation found |
| rsp_miss | output | 1 | Miss trap: software refill needed |
| rsp_fault | output | 1 | Protection violation |
| rsp_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| rsp_ref | output | 1 | Referenced flag of the matched slot after the access |
| rsp_mod | output | 1 | Modified flag of the matched slot after the access |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page of the translation being written |
| fill_pfn | input | PFN_W | Frame of the translation being written |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| inv_all | input | 1 | Invalidate every slot |
| inv_one | input | 1 | Invalidate the slot matching inv_vpn |
| inv_vpn | input | VPN_W | Page to invalidate |

## Verification
Every lookup result (hit, miss, fault, frame number and the updated flags) is registered once, so it is due in the cycle after the accepting edge. The bench drives each request at a falling edge and reads the response at the following falling edge. Fills and invalidations take effect on the edge they are sampled, so the next lookup reflects them. `req_ready` is combinational from `fill_valid` and is checked in the same half-cycle as the fill is driven. The check that no response follows an unaccepted request comes one falling edge later.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_BITS = 3;

  // Is an access of this type allowed by the permission bits?
  function automatic logic perm_ok(input logic [PERM_BITS-1:0] perm, input acc_e acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = perm[PERM_R];
      ACC_WRITE: ok = perm[PERM_W];
      ACC_EXEC:  ok = perm[PERM_X];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            hit
);

  // one comparator per slot, all evaluated in parallel
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = valid[i] && (tags[i] == key);
  end

endmodule

// File: rtl/xlat_lfsr.sv
module xlat_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= {{(W-1){1'b0}}, 1'b1};
    end else if (state[0]) begin
      state <= (state >> 1) ^ TAPS;
    end else begin
      state <= state >> 1;
    end
  end

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  parameter int RND_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [ENTRIES-1:0] match,
  input  logic [ENTRIES-1:0] valid,
  input  logic [RND_W-1:0]   rnd,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] match_idx, free_idx, rnd_idx;
  logic             any_match, any_free;

  always_comb begin
    match_idx = '0;
    any_match = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        match_idx = IDX_W'(i);
        any_match = 1'b1;
      end
    end
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign rnd_idx = IDX_W'(32'(rnd) % ENTRIES);

  always_comb begin
    if (any_match)     idx = match_idx;
    else if (any_free) idx = free_idx;
    else               idx = rnd_idx;
  end

  // R8
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(|match) && !(&valid)) |-> !valid[idx]);

  // R8
  victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (32'(idx) < ENTRIES));

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int RND_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_ref,
  output logic             rsp_mod,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm,
  input  logic             inv_all,
  input  logic             inv_one,
  input  logic [VPN_W-1:0] inv_vpn
);
  import xlat_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // slot storage
  logic [ENTRIES-1:0]                valid_q, ref_q, mod_q;
  logic [ENTRIES-1:0]                valid_d, ref_d, mod_d;
  logic [ENTRIES-1:0][VPN_W-1:0]     tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0]     pfn_q;
  logic [ENTRIES-1:0][PERM_BITS-1:0] perm_q;

  logic [ENTRIES-1:0] lk_vec, fl_vec, iv_vec;
  logic [IDX_W-1:0]   lk_idx, fl_idx;
  logic [RND_W-1:0]   rnd;
  logic               accept, lk_any, lk_ok, lk_hit, lk_fault;
  acc_e               acc;

  assign req_ready = !fill_valid;
  assign accept    = req_valid && req_ready;
  assign acc       = acc_e'(req_acc);

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .key(req_vpn), .hit(lk_vec));

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fl_match (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn), .hit(fl_vec));

  xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_iv_match (
    .valid(valid_q), .tags(tag_q), .key(inv_vpn), .hit(iv_vec));

  xlat_lfsr #(.W(RND_W), .TAPS(RND_W'(8'hB8))) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd));

  xlat_victim #(.ENTRIES(ENTRIES), .RND_W(RND_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .en(fill_valid),
    .match(fl_vec), .valid(valid_q), .rnd(rnd), .idx(fl_idx));

  // encode the (at most one) matching slot of the lookup
  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_vec[i]) lk_idx = IDX_W'(i);
    end
  end

  assign lk_any   = |lk_vec;
  assign lk_ok    = perm_ok(perm_q[lk_idx], acc);
  assign lk_hit   = lk_any && lk_ok;
  assign lk_fault = lk_any && !lk_ok;

  // next state of the per-slot flags
  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    mod_d   = mod_q;
    if (accept && lk_hit) begin
      ref_d[lk_idx] = 1'b1;
      if (acc == ACC_WRITE) mod_d[lk_idx] = 1'b1;
    end
    if (inv_all) begin
      valid_d = '0;
    end else if (inv_one) begin
      valid_d = valid_d & ~iv_vec;
    end
    if (fill_valid) begin
      valid_d[fl_idx] = 1'b1;
      ref_d[fl_idx]   = 1'b0;
      mod_d[fl_idx]   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      mod_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      mod_q   <= mod_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      pfn_q  <= '0;
      perm_q <= '0;
    end else if (fill_valid) begin
      tag_q[fl_idx]  <= fill_vpn;
      pfn_q[fl_idx]  <= fill_pfn;
      perm_q[fl_idx] <= fill_perm;
    end
  end

  // registered response, one cycle after acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
      rsp_ref   <= 1'b0;
      rsp_mod   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= accept && lk_hit;
      rsp_miss  <= accept && !lk_any;
      rsp_fault <= accept && lk_fault;
      rsp_pfn   <= (accept && lk_hit) ? pfn_q[lk_idx] : '0;
      rsp_ref   <= accept && lk_any && ref_d[lk_idx];
      rsp_mod   <= accept && lk_any && mod_d[lk_idx];
    end
  end

  // R9
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !fill_valid));

  // R3
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R8
  no_dup_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec));

  // R4
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_valid) |=> (valid_q == '0));

  // R6
  write_sets_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lk_hit && acc == ACC_WRITE) |=> (rsp_hit && rsp_ref && rsp_mod));

  // R7
  fault_no_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_pfn == '0 && !rsp_hit));

endmodule

// File: tb/xlat_buf_tb_top.sv
module xlat_buf_tb_top;

  localparam int ENTRIES = 8;
  localparam int VPN_W   = 20;
  localparam int PFN_W   = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [VPN_W-1:0] req_vpn;
  logic [1:0]       req_acc;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_mod;
  logic [PFN_W-1:0] rsp_pfn;
  logic             fill_valid;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;
  logic [2:0]       fill_perm;
  logic             inv_all, inv_one;
  logic [VPN_W-1:0] inv_vpn;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  xlat_buf #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn), .rsp_ref(rsp_ref), .rsp_mod(rsp_mod),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .inv_all(inv_all), .inv_one(inv_one), .inv_vpn(inv_vpn));

  // op: 0 fill (arg = perm), 1 lookup (arg = access), 2 drop one page, 3 drop all
  // flags: {hit, miss, fault, ref, mod}
  typedef struct packed {
    logic [1:0]       op;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic [2:0]       arg;
    logic [4:0]       flags;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 20'h00011, 20'hA0011, 3'd1, 5'b00000},
    '{2'd0, 20'h00022, 20'hB0022, 3'd3, 5'b00000},
    '{2'd0, 20'h00033, 20'hC0033, 3'd4, 5'b00000},
    '{2'd0, 20'h00055, 20'hE0055, 3'd1, 5'b00000},
    '{2'd1, 20'h00055, 20'h00000, 3'd1, 5'b00100},
    '{2'd1, 20'h00055, 20'hE0055, 3'd0, 5'b10010},
    '{2'd1, 20'h00011, 20'hA0011, 3'd0, 5'b10010},
    '{2'd1, 20'h00011, 20'h00000, 3'd1, 5'b00110},
    '{2'd1, 20'h00022, 20'hB0022, 3'd1, 5'b10011},
    '{2'd1, 20'h00022, 20'hB0022, 3'd0, 5'b10011},
    '{2'd1, 20'h00033, 20'hC0033, 3'd2, 5'b10010},
    '{2'd1, 20'h00033, 20'h00000, 3'd0, 5'b00110},
    '{2'd1, 20'h00044, 20'h00000, 3'd0, 5'b01000},
    '{2'd2, 20'h00033, 20'h00000, 3'd0, 5'b00000},
    '{2'd1, 20'h00033, 20'h00000, 3'd2, 5'b01000},
    '{2'd1, 20'h00022, 20'hB0022, 3'd0, 5'b10011},
    '{2'd0, 20'h00022, 20'hD0022, 3'd1, 5'b00000},
    '{2'd1, 20'h00022, 20'hD0022, 3'd0, 5'b10010},
    '{2'd1, 20'h00022, 20'h00000, 3'd1, 5'b00110},
    '{2'd1, 20'h00011, 20'h00000, 3'd3, 5'b00110},
    '{2'd3, 20'h00000, 20'h00000, 3'd0, 5'b00000},
    '{2'd1, 20'h00011, 20'h00000, 3'd0, 5'b01000},
    '{2'd1, 20'h00055, 20'h00000, 3'd0, 5'b01000}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p, input logic [2:0] pm);
    fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_perm = pm;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv_one(input logic [VPN_W-1:0] v);
    inv_one = 1'b1; inv_vpn = v;
    @(posedge clk); @(negedge clk);
    inv_one = 1'b0;
  endtask

  task automatic do_inv_all();
    inv_all = 1'b1;
    @(posedge clk); @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic do_lookup(input logic [VPN_W-1:0] v, input logic [1:0] a,
                           output logic [4:0] fl, output logic [PFN_W-1:0] pf);
    req_valid = 1'b1; req_vpn = v; req_acc = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R9 response one cycle after accept", longint'(rsp_valid), 1);
    fl = {rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_mod};
    pf = rsp_pfn;
  endtask

  function automatic string row_tag(input logic [4:0] fl);
    if (fl[4])      return "R6 permitted hit";
    else if (fl[2]) return "R7 protection fault";
    else            return "R3 miss trap";
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [4:0]       fl;
    logic [PFN_W-1:0] pf;
    int               miss_cnt;

    rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0; req_acc = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0;
    inv_all = 1'b0; inv_one = 1'b0; inv_vpn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    check(rsp_valid === 1'b0, "R9 no response after reset", longint'(rsp_valid), 0);
    check(req_ready === 1'b1, "R9 ready after reset", longint'(req_ready), 1);
    do_lookup(20'h00011, 2'd0, fl, pf);
    check(fl === 5'b01000, "R2 empty buffer misses", longint'(fl), 5'b01000);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      case (TBL[k].op)
        2'd0: do_fill(TBL[k].vpn, TBL[k].pfn, TBL[k].arg);
        2'd2: do_inv_one(TBL[k].vpn);
        2'd3: do_inv_all();
        default: begin
          do_lookup(TBL[k].vpn, TBL[k].arg[1:0], fl, pf);
          check(fl === TBL[k].flags, row_tag(TBL[k].flags), longint'(fl), longint'(TBL[k].flags));
          check(pf === TBL[k].pfn, "R6 R10 frame number", longint'(pf), longint'(TBL[k].pfn));
        end
      endcase
    end

    // R1: fill every slot, all translations hit
    for (int i = 0; i < ENTRIES; i++) do_fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 3'd7);
    for (int i = 0; i < ENTRIES; i++) begin
      do_lookup(20'h00100 + 20'(i), 2'd0, fl, pf);
      check(fl[4] === 1'b1 && pf === 20'h00200 + 20'(i), "R1 every slot usable",
            longint'(pf), longint'(20'h00200 + 20'(i)));
    end

    // R8: a freed slot is reused before any random eviction
    do_inv_one(20'h00103);
    do_fill(20'h001AA, 20'h002AA, 3'd7);
    miss_cnt = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (i != 3) begin
        do_lookup(20'h00100 + 20'(i), 2'd0, fl, pf);
        if (fl[4] !== 1'b1) miss_cnt++;
      end
    end
    do_lookup(20'h001AA, 2'd0, fl, pf);
    if (fl[4] !== 1'b1) miss_cnt++;
    check(miss_cnt == 0, "R8 free slot taken first", miss_cnt, 0);

    // R8: a full buffer evicts exactly one page
    do_fill(20'h001BB, 20'h002BB, 3'd7);
    do_lookup(20'h001BB, 2'd0, fl, pf);
    check(fl[4] === 1'b1 && pf === 20'h002BB, "R8 new page after eviction", longint'(pf), 20'h002BB);
    miss_cnt = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (i != 3) begin
        do_lookup(20'h00100 + 20'(i), 2'd0, fl, pf);
        if (fl[3] === 1'b1 && fl[4] !== 1'b1) miss_cnt++;
      end
    end
    do_lookup(20'h001AA, 2'd0, fl, pf);
    if (fl[3] === 1'b1 && fl[4] !== 1'b1) miss_cnt++;
    check(miss_cnt == 1, "R8 exactly one victim", miss_cnt, 1);

    // R9: fill has priority over a lookup in the same cycle
    fill_valid = 1'b1; fill_vpn = 20'h00400; fill_pfn = 20'h00401; fill_perm = 3'd1;
    req_valid = 1'b1; req_vpn = 20'h001BB; req_acc = 2'd0;
    #1;
    check(req_ready === 1'b0, "R9 ready low during fill", longint'(req_ready), 0);
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    check(rsp_valid === 1'b0, "R9 stalled request gives no response", longint'(rsp_valid), 0);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_hit === 1'b1, "R9 held request accepted later",
          longint'(rsp_hit), 1);

    // R4: drop-all together with a fill keeps the fill
    inv_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00300; fill_pfn = 20'h00301; fill_perm = 3'd1;
    @(posedge clk); @(negedge clk);
    inv_all = 1'b0; fill_valid = 1'b0;
    do_lookup(20'h00300, 2'd0, fl, pf);
    check(fl[4] === 1'b1 && pf === 20'h00301, "R4 fill survives flush", longint'(pf), 20'h00301);
    do_lookup(20'h00400, 2'd0, fl, pf);
    check(fl === 5'b01000, "R4 flush removes older pages", longint'(fl), 5'b01000);

    // R5: dropping an absent page changes nothing
    do_inv_one(20'h00999);
    do_lookup(20'h00300, 2'd0, fl, pf);
    check(fl[4] === 1'b1 && pf === 20'h00301, "R5 unrelated drop ignored", longint'(pf), 20'h00301);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule